// File: doc/BRIEF.md
# I2C Target Register Control Port

This block is an I2C target that lets an external bus controller read and write a bank of 8-bit configuration registers. Both bus lines are brought into the system clock domain through a synchroniser. The synchronised copies are compared with their previous values to find SCL edges and START and STOP conditions. The target answers one 7-bit device address. The upper six bits of that address are fixed by a parameter, and the lowest bit follows a strap input. The target drives SDA only by pulling it low, through an output-enable.

A write transaction sends a pointer byte first. Each byte after the pointer is a data byte, and the block presents it on a one-cycle register write strobe together with the pointer as the register index. A read transaction has no pointer byte: data is shifted out straight after the address acknowledge. The byte comes from the register the current pointer selects, read through a combinational read-data input. The top bit of the pointer byte enables auto-increment, so one transaction can cover a run of consecutive registers. The pointer keeps its value across transactions.

Top module: `i2c_regport`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {6'b001000, addr_sel}. It acknowledges by holding sda_oe high through the ninth SCL clock.
- R2: If the address does not match, the target leaves sda_oe low. It then issues no register writes and drives nothing until the next START.
- R3: Bit 0 of the address byte selects the direction: 0 for a write, 1 for a read.
- R4: In a write, the first byte after the address loads the pointer. Every later byte produces a single-cycle reg_we with reg_addr equal to the pointer and reg_wdata equal to the byte. Every one of these bytes is acknowledged.
- R5: Pointer byte fields: bit 7 is the increment enable, bits 3..0 give the register index, and bits 6..4 are ignored.
- R6: With the increment enable at 0, the pointer does not move. With it at 1, the pointer advances by one after each data byte written or read, whether that read byte was ACKed or NACKed. The pointer wraps from 15 to 0.
- R7: In a read, the byte at the pointer is shifted out MSB first, starting straight after the address acknowledge. When the controller ACKs, the next byte follows. When it NACKs, SDA is released and the target waits for STOP or START.
- R8: After reset the pointer is 0, the increment enable is 0, sda_oe is low and reg_we is low.
- R9: A STOP in the middle of a byte abandons that byte without a write. A START at any point restarts address decoding. The pointer is kept across STOP and repeated START.
- R10: sda_oe is raised only while SCL is low. Incoming bits are taken on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap giving the address LSB |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| reg_addr | output | 4 | Register index (current pointer) |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
A wrong pointer value shows up at the ports in one of two places. In a write, the wrong index appears on reg_addr in the same cycle as the reg_we strobe. In a read, the wrong register's byte goes out on SDA one SCL period after the address acknowledge. A wrong increment flag shows up only on the second byte of a burst, so the bench runs bursts that cross the 15-to-0 wrap. A wrong bus state shows up within one byte as a missing or extra acknowledge. Aborts and mismatched addresses are also checked for writes that should never appear.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_TXLD,
        ST_WAIT
    } state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } kind_e;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl_sh;
        logic [PIPE_W-1:0] sda_sh;
    } sync_s;

    sync_s sync_d, sync_q;

    logic scl_now, scl_prev, sda_prev;

    always_comb begin
        sync_d        = sync_q;
        sync_d.scl_sh = {sync_q.scl_sh[PIPE_W-2:0], scl_i};
        sync_d.sda_sh = {sync_q.sda_sh[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{scl_sh: '1, sda_sh: '1};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_now   = sync_q.scl_sh[STAGES-1];
    assign scl_prev  = sync_q.scl_sh[STAGES];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign sda_prev  = sync_q.sda_sh[STAGES];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_regport_ctrl.sv
module i2c_regport_ctrl
    import i2c_regport_pkg::*;
#(
    parameter int         PTR_W       = 4,
    parameter logic [5:0] DEV_ADDR_HI = 6'b001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we
);
    localparam int INC_BIT  = BYTE_W - 1;
    localparam int LAST_BIT = BYTE_W - 1;

    typedef struct packed {
        state_e            st;
        kind_e             kind;
        logic [2:0]        bcnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic [PTR_W-1:0]  ptr;
        logic              inc;
        logic              oe;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic  addr_hit;
    logic [PTR_W-1:0] ptr_next;

    assign addr_hit = (c_q.sh[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel});
    assign ptr_next = c_q.ptr + PTR_W'(c_q.inc);

    always_comb begin
        c_d    = c_q;
        c_d.we = 1'b0;
        if (stop_det) begin
            c_d.st = ST_IDLE;
            c_d.oe = 1'b0;
        end else if (start_det) begin
            c_d.st   = ST_RX;
            c_d.kind = K_ADDR;
            c_d.bcnt = '0;
            c_d.oe   = 1'b0;
        end else begin
            case (c_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        c_d.sh = {c_q.sh[BYTE_W-2:0], sda_s};
                        if (c_q.bcnt == 3'(LAST_BIT)) begin
                            c_d.st = ST_RX_END;
                        end else begin
                            c_d.bcnt = c_q.bcnt + 3'd1;
                        end
                    end
                end
                ST_RX_END: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b1;
                        c_d.st = ST_ACK;
                        case (c_q.kind)
                            K_ADDR: begin
                                if (addr_hit) begin
                                    c_d.rw = c_q.sh[0];
                                end else begin
                                    c_d.oe = 1'b0;
                                    c_d.st = ST_WAIT;
                                end
                            end
                            K_PTR: begin
                                c_d.ptr = c_q.sh[PTR_W-1:0];
                                c_d.inc = c_q.sh[INC_BIT];
                            end
                            default: begin
                                c_d.we    = 1'b1;
                                c_d.wdata = c_q.sh;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        c_d.bcnt = '0;
                        if (c_q.kind == K_ADDR && c_q.rw) begin
                            c_d.sh = reg_rdata;
                            c_d.oe = ~reg_rdata[LAST_BIT];
                            c_d.st = ST_TX;
                        end else begin
                            c_d.oe   = 1'b0;
                            c_d.st   = ST_RX;
                            c_d.kind = (c_q.kind == K_ADDR) ? K_PTR : K_DATA;
                            if (c_q.kind == K_DATA) begin
                                c_d.ptr = ptr_next;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (c_q.bcnt == 3'(LAST_BIT)) begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_RACK;
                        end else begin
                            c_d.bcnt = c_q.bcnt + 3'd1;
                            c_d.sh   = {c_q.sh[BYTE_W-2:0], 1'b0};
                            c_d.oe   = ~c_q.sh[LAST_BIT-1];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        c_d.ptr = ptr_next;
                        c_d.st  = sda_s ? ST_WAIT : ST_TXLD;
                    end
                end
                ST_TXLD: begin
                    if (scl_fall) begin
                        c_d.sh   = reg_rdata;
                        c_d.oe   = ~reg_rdata[LAST_BIT];
                        c_d.bcnt = '0;
                        c_d.st   = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, kind: K_ADDR, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe    = c_q.oe;
    assign reg_addr  = c_q.ptr;
    assign reg_wdata = c_q.wdata;
    assign reg_we    = c_q.we;
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
    parameter int         SYNC_STAGES = 2,
    parameter int         PTR_W       = 4,
    parameter logic [5:0] DEV_ADDR_HI = 6'b001000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel,
    output logic             sda_oe,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_regport_ctrl #(.PTR_W(PTR_W), .DEV_ADDR_HI(DEV_ADDR_HI)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .addr_sel  (addr_sel),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             reg_we,
    input logic [PTR_W-1:0] reg_addr
);
    // R10: the target starts pulling SDA only while SCL is low
    p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R4: the write strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4: writes are issued in the SCL low phase after the eighth bit
    p_we_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_i);

    // R6: the index does not move in the cycle after a write strobe
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $stable(reg_addr));

    // R6: a pointer change during SCL high is a read advance of exactly one
    p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg_addr) && scl_i) |-> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

    // R8: outputs are quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r8: assert (!sda_oe && !reg_we);
        end
    end
endmodule

bind i2c_regport i2c_regport_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
    localparam int CLK_P = 10;
    localparam int Q     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe, reg_we;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [16];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0]  m_mem [16];
    logic [3:0]  m_ptr = '0;
    logic        m_inc = 1'b0;
    logic [11:0] exp_wr [$];
    logic [7:0]  wbuf [4];
    bit          oe_seen = 0;
    logic        prev_oe = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regport uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    // register file the block writes into
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every clock: write strobes against the reference queue, and the SCL phase of SDA drive
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (exp_wr.size() == 0) begin
                    chk(0, "R2 R4 R9 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
                end
            end
            chk(!(sda_oe && !prev_oe && scl_m), "R10 drive start in SCL high", sda_oe, 0);
            if (sda_oe) oe_seen = 1;
        end
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        s = sda_bus; tick(Q/2);
        scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic m_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~m_ack, s);
    endtask

    task automatic dev_write(input logic [7:0] ptrb, input int n, input bit do_stop);
        logic a;
        i2c_start();
        wr_byte({6'b001000, addr_sel, 1'b0}, a);
        chk(a, "R1 R3 write address ack", a, 1);
        wr_byte(ptrb, a);
        chk(a, "R4 pointer ack", a, 1);
        m_ptr = ptrb[3:0];
        m_inc = ptrb[7];
        for (int k = 0; k < n; k++) begin
            exp_wr.push_back({m_ptr, wbuf[k]});
            m_mem[m_ptr] = wbuf[k];
            wr_byte(wbuf[k], a);
            chk(a, "R4 data ack", a, 1);
            m_ptr = m_ptr + 4'(m_inc);
        end
        if (do_stop) i2c_stop();
    endtask

    task automatic dev_read(input int n);
        logic a;
        logic [7:0] d;
        i2c_start();
        wr_byte({6'b001000, addr_sel, 1'b1}, a);
        chk(a, "R1 R3 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, d);
            chk(d == m_mem[m_ptr], "R6 R7 read data", d, m_mem[m_ptr]);
            m_ptr = m_ptr + 4'(m_inc);
        end
        tick(Q);
        chk(!sda_oe, "R7 release after NACK", sda_oe, 0);
        i2c_stop();
    endtask

    initial begin
        logic a, s;
        for (int i = 0; i < 16; i++) begin
            mem[i]   = 8'hA0 + 8'(i);
            m_mem[i] = 8'hA0 + 8'(i);
        end
        tick(5);
        chk(!sda_oe && !reg_we && reg_addr == 4'd0, "R8 reset state", {sda_oe, reg_we, reg_addr}, 0);
        rst_n = 1'b1;
        tick(5);

        // R5 R6: reserved bits set, no increment, two bytes into register 5
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        dev_write(8'h75, 2, 1);
        chk(reg_addr == 4'd5, "R6 pointer fixed with increment off", reg_addr, 5);

        // R7: read with increment off repeats the same register
        dev_read(2);

        // R6: burst write across the wrap
        wbuf[0] = 8'h31; wbuf[1] = 8'h32; wbuf[2] = 8'h33;
        dev_write(8'h8E, 3, 1);
        chk(reg_addr == 4'd1, "R6 pointer after wrap", reg_addr, 1);

        // R1: strap high changes the address
        addr_sel = 1'b1;
        tick(Q);
        // R9: pointer byte only, then repeated START into a wrapping read burst
        dev_write(8'h8E, 0, 0);
        dev_read(3);

        // R2: wrong address is ignored until the next START
        oe_seen = 0;
        i2c_start();
        wr_byte(8'h20, a);
        chk(!a, "R2 no ack on mismatch", a, 0);
        wr_byte(8'h03, a);
        chk(!a, "R2 no ack after mismatch", a, 0);
        wr_byte(8'h5A, a);
        chk(!oe_seen, "R2 SDA never driven", oe_seen, 0);
        i2c_stop();

        // R9: STOP in the middle of a data byte writes nothing
        dev_write(8'h02, 0, 0);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        i2c_stop();
        chk(reg_addr == 4'd2, "R9 pointer kept over abort", reg_addr, 2);

        // R9: START in the middle of an address byte restarts decoding
        i2c_start();
        for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
        dev_read(1);

        tick(20);
        chk(exp_wr.size() == 0, "R4 R9 writes outstanding", exp_wr.size(), 0);
        for (int i = 0; i < 16; i++)
            chk(mem[i] == m_mem[i], "R4 register contents", mem[i], m_mem[i]);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule